// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous static RAM whose read path is flow-through. Address, control and write data are all sampled on the rising edge of one clock. The word stored at the sampled address then reaches the data output in that same cycle, with no output register in between. An access starts with an address strobe. An advance input then steps a 2-bit beat counter, which supplies the two low address bits of each later beat. The order of the beats is either a linear count or an interleaved (XOR) order. The order is chosen when the strobe is taken, and the burst always stays inside an aligned block of four words.

Writes are controlled at three levels. A global write stores every byte lane. Without it, a byte-write qualifier must be asserted before the individual lane enables have any effect. Three chip enables of mixed polarity select the device for depth expansion. An asynchronous output enable gates the data output. A sleep input freezes all state and blanks the output, and the stored words are kept.

The data port has no valid/ready handshake, because an SRAM cannot apply back-pressure. Read data is valid only while `dq_oe_o` is high, and the host takes it in that cycle. The control pins are plain levels. An active-low reset clears only the access state and leaves the array contents alone.

Top module: `fts_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe, `dq_oe_o` is 0.
- R2: A strobe edge (`strobe_n_i`=0) taken with `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0 and without a write loads the address. In the cycle after that edge, with `oe_n_i`=0, `dq_oe_o`=1 and `dq_o` holds the word stored at that address.
- R3: If the strobe had `burst_lin_i`=1, each advance edge (`adv_n_i`=0, no strobe) makes the low two address bits (start+beat) mod 4. Beat counts 0,1,2,3 and then wraps to 0, and the upper bits stay fixed.
- R4: If the strobe had `burst_lin_i`=0, the low two address bits are start XOR beat.
- R5: With `gw_n_i`=1 and `bwe_n_i`=0, a write edge stores lane k (bits k*9 to k*9+8) only where `lane_we_n_i[k]`=0. The other lanes keep their contents.
- R6: With `gw_n_i`=1 and `bwe_n_i`=1, `lane_we_n_i` is ignored, nothing is written and the cycle is a read.
- R7: With `gw_n_i`=0, every lane is written, whatever `bwe_n_i` and `lane_we_n_i` say.
- R8: A strobe with any chip enable inactive deselects the device. Its write is discarded and `dq_oe_o` stays 0 until a selecting strobe.
- R9: When `oe_n_i`=1, `dq_oe_o` is 0 and `dq_o` is 0 in the same cycle, with no clock edge needed.
- R10: While `sleep_i`=1, `dq_oe_o` is 0 and strobes, advances and writes have no effect. After `sleep_i` returns to 0, the burst resumes at the address it held.
- R11: In the cycle after a write edge, `dq_oe_o` is 0. If the next edge neither strobes nor advances, the written word is then read back.
- R12: An edge with no strobe and no advance keeps the current address and output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| rst_n | input | 1 | Active-low reset of the access state |
| adr_i | input | AW (10) | Word address |
| strobe_n_i | input | 1 | Active-low address strobe, starts an access |
| adv_n_i | input | 1 | Active-low burst advance |
| burst_lin_i | input | 1 | 1 linear order, 0 interleaved order |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Active-low global write, all lanes |
| bwe_n_i | input | 1 | Active-low byte-write qualifier |
| lane_we_n_i | input | LANES (2) | Active-low per-lane write enables |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Power-down hold, active high |
| dq_i | input | LANES*LW (18) | Write data |
| dq_o | output | LANES*LW (18) | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Output driven (low means high impedance) |

## Verification
The read path has no output register, so a wrong beat count, base address or order bit shows up as a wrong word on `dq_o` in the very cycle after the edge that set it. A lane mask that is wrong has no effect on the write cycle itself. It becomes visible one idle cycle later, when the word is read back with the wrong lane bits. A select or read flag that is stuck shows up at once on `dq_oe_o`. A sleep hold that leaks appears when sleep ends, as a resumed burst word that is wrong or as a location that was overwritten.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic {
    ORD_INTLV = 1'b0,
    ORD_LIN   = 1'b1
  } burst_ord_e;

  // Low two address bits for a given beat of a burst.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input burst_ord_e ord);
    if (ord == ORD_LIN) return start + beat;
    else                return start ^ beat;
  endfunction
endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          strobe_i,
  input  logic          sel_i,
  input  logic          adv_i,
  input  logic [AW-1:0] adr_i,
  input  burst_ord_e    ord_i,
  output logic          nxt_act_o,
  output logic [AW-1:0] nxt_addr_o,
  output logic [AW-1:0] addr_o
);
  logic          act_q, act_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d;
  burst_ord_e    ord_q, ord_d;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    ord_d  = ord_q;
    if (!hold_i) begin
      if (strobe_i) begin
        act_d = sel_i;
        if (sel_i) begin
          base_d = adr_i;
          beat_d = 2'd0;
          ord_d  = ord_i;
        end
      end else if (adv_i && act_q) begin
        beat_d = beat_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
      ord_q  <= ORD_LIN;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      ord_q  <= ord_d;
    end
  end

  assign nxt_act_o  = act_d;
  assign nxt_addr_o = {base_d[AW-1:2], beat_lo(base_d[1:0], beat_d, ord_d)};
  assign addr_o     = {base_q[AW-1:2], beat_lo(base_q[1:0], beat_q, ord_q)};

  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !strobe_i && adv_i && act_q && ord_q == ORD_LIN)
      |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);

  p_block_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !strobe_i && adv_i && act_q)
      |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));

  p_intlv_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !strobe_i && adv_i && act_q && ord_q == ORD_INTLV)
      |=> addr_o[1:0] != $past(addr_o[1:0]));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !adv_i) |=> $stable(addr_o) && $stable(act_q));

  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(addr_o) && $stable(act_q));
endmodule

// File: rtl/fts_wr_qual.sv
module fts_wr_qual #(
  parameter int LANES = 2
) (
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_we_n_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    if (!gw_n_i)       mask_o = '1;
    else if (!bwe_n_i) mask_o = ~lane_we_n_i;
    else               mask_o = '0;
  end
endmodule

// File: rtl/fts_lane_ram.sv
module fts_lane_ram #(
  parameter int AW = 10,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [LW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter  int AW    = 10,
  parameter  int LANES = 2,
  parameter  int LW    = 9,
  localparam int DW    = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    adr_i,
  input  logic             strobe_n_i,
  input  logic             adv_n_i,
  input  logic             burst_lin_i,
  input  logic             ce1_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_we_n_i,
  input  logic             oe_n_i,
  input  logic             sleep_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  logic             ce_ok;
  logic             nxt_act;
  logic [AW-1:0]    nxt_addr;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] mask;
  logic             wr_go;
  logic             rd_q;
  logic [DW-1:0]    rdata;

  assign ce_ok = !ce1_n_i && ce2_i && !ce3_n_i;

  fts_burst_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (sleep_i),
    .strobe_i   (!strobe_n_i),
    .sel_i      (ce_ok),
    .adv_i      (!adv_n_i),
    .adr_i      (adr_i),
    .ord_i      (burst_ord_e'(burst_lin_i)),
    .nxt_act_o  (nxt_act),
    .nxt_addr_o (nxt_addr),
    .addr_o     (cur_addr)
  );

  fts_wr_qual #(.LANES(LANES)) u_qual (
    .gw_n_i      (gw_n_i),
    .bwe_n_i     (bwe_n_i),
    .lane_we_n_i (lane_we_n_i),
    .mask_o      (mask)
  );

  assign wr_go = !sleep_i && nxt_act;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fts_lane_ram #(.AW(AW), .LW(LW)) u_ram (
      .clk     (clk),
      .we_i    (wr_go && mask[k]),
      .waddr_i (nxt_addr),
      .wdata_i (dq_i[k*LW +: LW]),
      .raddr_i (cur_addr),
      .rdata_o (rdata[k*LW +: LW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_q <= 1'b0;
    else if (!sleep_i) rd_q <= nxt_act && !(|mask);
  end

  assign dq_oe_o = rd_q && !oe_n_i && !sleep_i;
  assign dq_o    = dq_oe_o ? rdata : '0;

  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !strobe_n_i && !ce_ok) |=> !rd_q);

  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (|mask)) |=> !dq_oe_o);

  p_desel_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n_i && !ce_ok) |-> !wr_go);

  always_comb begin
    if (rst_n === 1'b1 && gw_n_i === 1'b0)
      p_global_all_r7: assert (&mask);
    if (rst_n === 1'b1 && gw_n_i === 1'b1 && bwe_n_i === 1'b1)
      p_no_qual_r6: assert (mask == '0);
  end
endmodule

// File: tb/sim_fts_sram.sv
module sim_fts_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LANES = 2;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AW-1:0]    adr = '0;
  logic             strobe_n = 1'b1;
  logic             adv_n = 1'b1;
  logic             lin = 1'b1;
  logic             ce1_n = 1'b0;
  logic             ce2 = 1'b1;
  logic             ce3_n = 1'b0;
  logic             gw_n = 1'b1;
  logic             bwe_n = 1'b1;
  logic [LANES-1:0] lane_n = '1;
  logic             oe_n = 1'b0;
  logic             sleep = 1'b0;
  logic [DW-1:0]    dq_in = '0;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fts_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .adr_i(adr), .strobe_n_i(strobe_n),
    .adv_n_i(adv_n), .burst_lin_i(lin), .ce1_n_i(ce1_n), .ce2_i(ce2),
    .ce3_n_i(ce3_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n), .lane_we_n_i(lane_n),
    .oe_n_i(oe_n), .sleep_i(sleep), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[8:0] ^ 9'h155, a[8:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle();
    strobe_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
    lane_n = '1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    strobe_n = 1'b0; adr = a; gw_n = 1'b0; dq_in = d;
    tick();
    idle();
  endtask

  task automatic rd_start(input logic [AW-1:0] a, input logic mode);
    strobe_n = 1'b0; adr = a; lin = mode;
    tick();
    idle();
  endtask

  task automatic advance();
    adv_n = 1'b0;
    tick();
    idle();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 oe in reset", DW'(dq_oe), DW'(1'b0));
    rst_n = 1'b1;
    tick();
    chk("R1 oe after reset", DW'(dq_oe), DW'(1'b0));
  endtask

  task automatic t_write_read();
    wr_word(10'h005, pat(10'h005));
    chk("R11 quiet after write", DW'(dq_oe), DW'(1'b0));
    tick();
    chk("R11 readback oe", DW'(dq_oe), DW'(1'b1));
    chk("R11 readback data", dq_out, pat(10'h005));
    for (int a = 16; a < 20; a++) wr_word(AW'(a), pat(AW'(a)));
    rd_start(10'h005, 1'b1);
    chk("R2 read oe", DW'(dq_oe), DW'(1'b1));
    chk("R2 read data", dq_out, pat(10'h005));
  endtask

  task automatic t_linear();
    logic [AW-1:0] seq [4] = '{10'h013, 10'h010, 10'h011, 10'h012};
    rd_start(10'h012, 1'b1);
    chk("R3 first beat", dq_out, pat(10'h012));
    for (int i = 0; i < 4; i++) begin
      advance();
      chk("R3 linear beat", dq_out, pat(seq[i]));
    end
  endtask

  task automatic t_intlv();
    logic [AW-1:0] seq [4] = '{10'h010, 10'h013, 10'h012, 10'h011};
    rd_start(10'h011, 1'b0);
    chk("R4 first beat", dq_out, pat(10'h011));
    for (int i = 0; i < 4; i++) begin
      advance();
      chk("R4 interleaved beat", dq_out, pat(seq[i]));
    end
  endtask

  task automatic t_hold();
    rd_start(10'h013, 1'b1);
    tick();
    tick();
    chk("R12 hold oe", DW'(dq_oe), DW'(1'b1));
    chk("R12 hold data", dq_out, pat(10'h013));
  endtask

  task automatic t_bytes();
    wr_word(10'h020, '0);
    strobe_n = 1'b0; adr = 10'h020; bwe_n = 1'b0; lane_n = 2'b10;
    dq_in = 18'h3FFFF;
    tick(); idle(); tick();
    chk("R5 lane0 only", dq_out, 18'h001FF);
    strobe_n = 1'b0; adr = 10'h020; bwe_n = 1'b1; lane_n = 2'b00;
    dq_in = 18'h3FFFF;
    tick(); idle();
    chk("R6 ignored oe", DW'(dq_oe), DW'(1'b1));
    chk("R6 ignored data", dq_out, 18'h001FF);
    strobe_n = 1'b0; adr = 10'h020; gw_n = 1'b0; bwe_n = 1'b1;
    dq_in = 18'h12345;
    tick(); idle(); tick();
    chk("R7 global write", dq_out, 18'h12345);
    strobe_n = 1'b0; adr = 10'h020; gw_n = 1'b0; bwe_n = 1'b0;
    lane_n = 2'b10; dq_in = 18'h2AAAA;
    tick(); idle(); tick();
    chk("R7 global overrides lanes", dq_out, 18'h2AAAA);
  endtask

  task automatic t_chip();
    for (int v = 0; v < 3; v++) begin
      strobe_n = 1'b0; adr = 10'h020; gw_n = 1'b0; dq_in = '0;
      ce1_n = (v == 0); ce2 = (v != 1); ce3_n = (v == 2);
      tick(); idle();
      chk("R8 deselect oe", DW'(dq_oe), DW'(1'b0));
      tick();
      chk("R8 stays deselected", DW'(dq_oe), DW'(1'b0));
    end
    rd_start(10'h020, 1'b1);
    chk("R8 write discarded", dq_out, 18'h2AAAA);
  endtask

  task automatic t_oe();
    rd_start(10'h010, 1'b1);
    oe_n = 1'b1;
    #1;
    chk("R9 oe off", DW'(dq_oe), DW'(1'b0));
    chk("R9 data zero", dq_out, '0);
    oe_n = 1'b0;
    #1;
    chk("R9 oe back", DW'(dq_oe), DW'(1'b1));
    chk("R9 data back", dq_out, pat(10'h010));
  endtask

  task automatic t_sleep();
    rd_start(10'h010, 1'b1);
    advance();
    sleep = 1'b1;
    #1;
    chk("R10 sleep blanks", DW'(dq_oe), DW'(1'b0));
    strobe_n = 1'b0; adv_n = 1'b0; adr = 10'h013; gw_n = 1'b0; dq_in = '0;
    tick();
    tick();
    idle();
    #1;
    chk("R10 resume oe", DW'(dq_oe), DW'(1'b1));
    chk("R10 resume word", dq_out, pat(10'h011));
    advance();
    chk("R10 resume advance", dq_out, pat(10'h012));
    rd_start(10'h013, 1'b1);
    chk("R10 no write in sleep", dq_out, pat(10'h013));
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_linear();
    t_intlv();
    t_hold();
    t_bytes();
    t_chip();
    t_oe();
    t_sleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule